// File: doc/BRIEF.md
# ADC Frame Sequencer Status Controller

This block keeps track of conversion frames for an ADC controller. A timer trigger opens a frame. A frame-done pulse from the conversion engine closes it. Each closed frame sets a frame status bit. A programmable frame limit and a running frame counter together mark the end of a longer sequence with a separate last-frame status bit. The limit may be rewritten while frames are running, which lets software push that flag further out.

Status must be cleared by a write-one-to-clear register access before the next timer trigger. The access may come from an interrupt handler or from a DMA write. A trigger that finds frame status still pending is an overrun. The overrun sets a sticky error, raises a separate error interrupt and stops sampling. Sampling resumes only after software clears the error and arms the block again.

The register port has four word addresses, selected by `wr_addr_i`:

| Address | Function |
| --- | --- |
| 0 | Control |
| 1 | Frame limit |
| 2 | Status (write-one-to-clear) |
| 3 | Interrupt mask |

Top module: `frmseq_ctrl`

## Requirements
- R1: After reset, status_o is 000, frame_cnt_o is 0, and running_o, busy_o, frame_irq_o and err_irq_o are all low.
- R2: A write of 1 in data bit 0 to address 0 (control) sets running_o on the next cycle, provided the error bit (status bit 2) is clear.
- R3: A trigger while running, not busy and with status bits 1:0 clear sets busy_o. A frame-done pulse while busy clears busy_o and sets status bit 0 (frame done).
- R4: With a frame limit (address 1) of zero, every completed frame sets status bit 0 and never sets status bit 1 (last frame); frame_cnt_o stays 0.
- R5: With a non-zero limit N, frame_cnt_o counts completed frames. The frame that completes while the count equals N sets status bit 1 and returns the count to 0, so the flag fires once every N+1 frames.
- R6: If the limit is rewritten below the current count, the count keeps incrementing and wraps at its width. Status bit 1 fires only on an exact match, never at once.
- R7: A trigger while running with status bit 0 or 1 still set is an overrun. It sets status bit 2, drops running_o and busy_o, and raises err_irq_o.
- R8: While status bit 2 is set, triggers start no frame (busy_o stays low).
- R9: Status bit 2 is sticky. An arming write is ignored while it is set. After a write-one-to-clear of bit 2 and a new arming write, frames start again.
- R10: Writing to address 2 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A set and a clear of the same bit in one cycle leave the bit set.
- R11: frame_irq_o is high when any of status bits 1:0 is set together with its mask bit (address 3, bits 1:0). err_irq_o follows status bit 2.
- R12: A trigger that arrives while a frame is busy and status bits 1:0 are clear is ignored: busy_o stays high, no error is set and the count does not change.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Timer trigger pulse |
| done_i | input | 1 | All conversion events of the current frame finished |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| status_o | output | 3 | Status: bit 0 frame done, bit 1 last frame, bit 2 overrun error |
| frame_cnt_o | output | CNT_W | Completed frames in the current sequence |
| running_o | output | 1 | Sampling armed |
| busy_o | output | 1 | Frame in progress |
| frame_irq_o | output | 1 | Masked frame interrupt |
| err_irq_o | output | 1 | Overrun error interrupt |

## Verification
A wrong frame counter shows at frame_cnt_o one cycle after the frame-done pulse. Its effect on the last-frame flag appears only at the matching frame, so the lowered-limit case runs the count through a full wrap and checks every frame on the way. A lost overrun or a leaking error state shows on status_o and running_o in the cycle after the offending trigger. A broken busy state shows one cycle after a trigger, as a missing busy_o, a false error or an extra count.

// File: rtl/frmseq_pkg.sv
package frmseq_pkg;

    localparam int ADDR_W = 2;
    localparam int ST_W   = 3;
    localparam int MASK_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_LIMIT = 2'd1,
        REG_STAT  = 2'd2,
        REG_MASK  = 2'd3
    } reg_sel_e;

    // status bit order is visible at the port and in the clear mask
    typedef struct packed {
        logic err;
        logic last;
        logic frame;
    } stat_t;

    function automatic logic pending(input stat_t s);
        return s.frame | s.last;
    endfunction

    function automatic logic irq_merge(input stat_t s, input logic [MASK_W-1:0] m);
        return (s.frame & m[0]) | (s.last & m[1]);
    endfunction

endpackage

// File: rtl/frmseq_regs.sv
module frmseq_regs
    import frmseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  limit_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              arm_req_o,
    output stat_t             clr_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_o <= '0;
            mask_o  <= '0;
        end else if (wr_en_i) begin
            if (sel == REG_LIMIT) limit_o <= wr_data_i[CNT_W-1:0];
            if (sel == REG_MASK)  mask_o  <= wr_data_i[MASK_W-1:0];
        end
    end

    always_comb begin
        arm_req_o = wr_en_i && (sel == REG_CTRL) && wr_data_i[0];
        clr_o     = '0;
        if (wr_en_i && sel == REG_STAT) clr_o = stat_t'(wr_data_i[ST_W-1:0]);
    end

endmodule

// File: rtl/frmseq_counter.sv
module frmseq_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_hit_o
);
    logic match;
    assign match      = (cnt_o == limit_i);
    assign last_hit_o = fin_i && match && (limit_i != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (fin_i)
            cnt_o <= match ? '0 : cnt_o + 1'b1;
    end

endmodule

// File: rtl/frmseq_core.sv
module frmseq_core
    import frmseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trig_i,
    input  logic  done_i,
    input  logic  arm_req_i,
    input  stat_t clr_i,
    input  logic  last_hit_i,
    output stat_t stat_o,
    output logic  running_o,
    output logic  busy_o,
    output logic  fin_o
);
    logic  overrun, start;
    stat_t stat_d;

    assign overrun = trig_i && running_o && pending(stat_o);
    assign start   = trig_i && running_o && !pending(stat_o) && !busy_o;
    assign fin_o   = done_i && busy_o && !overrun;

    always_comb begin
        stat_d = stat_o & ~clr_i;
        if (fin_o)      stat_d.frame = 1'b1;
        if (last_hit_i) stat_d.last  = 1'b1;
        if (overrun)    stat_d.err   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o    <= '0;
            running_o <= 1'b0;
            busy_o    <= 1'b0;
        end else begin
            stat_o <= stat_d;
            if (overrun)
                running_o <= 1'b0;
            else if (arm_req_i && !stat_o.err)
                running_o <= 1'b1;
            if (overrun || fin_o)
                busy_o <= 1'b0;
            else if (start)
                busy_o <= 1'b1;
        end
    end

endmodule

// File: rtl/frmseq_ctrl.sv
module frmseq_ctrl
    import frmseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              done_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [2:0]        status_o,
    output logic [CNT_W-1:0]  frame_cnt_o,
    output logic              running_o,
    output logic              busy_o,
    output logic              frame_irq_o,
    output logic              err_irq_o
);
    logic [CNT_W-1:0]  limit_q;
    logic [MASK_W-1:0] mask_q;
    logic              arm_req, fin, last_hit;
    stat_t             clr, stat;

    frmseq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .limit_o(limit_q), .mask_o(mask_q),
        .arm_req_o(arm_req), .clr_o(clr)
    );

    frmseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .fin_i(fin), .limit_i(limit_q),
        .cnt_o(frame_cnt_o), .last_hit_o(last_hit)
    );

    frmseq_core u_core (
        .clk(clk), .rst(rst), .trig_i(trig_i), .done_i(done_i),
        .arm_req_i(arm_req), .clr_i(clr), .last_hit_i(last_hit),
        .stat_o(stat), .running_o(running_o), .busy_o(busy_o), .fin_o(fin)
    );

    assign status_o    = stat;
    assign frame_irq_o = irq_merge(stat, mask_q);
    assign err_irq_o   = stat.err;

endmodule

// File: rtl/frmseq_ctrl_chk.sv
module frmseq_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic              done_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [2:0]        status_o,
    input logic              running_o,
    input logic              busy_o,
    input logic [CNT_W-1:0]  limit_q
);
    // R7
    overrun_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        trig_i && running_o && (status_o[0] || status_o[1]) |=> status_o[2] && !running_o && !busy_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[2] && !(wr_en_i && wr_addr_i == 2'd2 && wr_data_i[2]) |=> status_o[2]);

    // R8
    halted_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[2] |-> !running_o && !busy_o);

    // R3
    frame_done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && done_i && !trig_i |=> status_o[0] && !busy_o);

    // R12
    busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && trig_i && !done_i && !status_o[0] && !status_o[1] |=> busy_o && !status_o[2]);

    // R4
    no_last_when_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && done_i && limit_q == '0 && !status_o[1] |=> !status_o[1]);

endmodule

bind frmseq_ctrl frmseq_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .trig_i(trig_i), .done_i(done_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .status_o(status_o),
    .running_o(running_o), .busy_o(busy_o), .limit_q(limit_q)
);

// File: tb/frmseq_ctrl_test.sv
`timescale 1ns/1ps
module frmseq_ctrl_test;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0, done = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0] status;
    logic [CNT_W-1:0] cnt;
    logic running, busy, firq, eirq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [2:0]       st;
        logic [CNT_W-1:0] c;
        logic             run;
        logic             bsy;
        logic             fi;
        logic             ei;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    frmseq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .trig_i(trig), .done_i(done), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .status_o(status),
        .frame_cnt_o(cnt), .running_o(running), .busy_o(busy),
        .frame_irq_o(firq), .err_irq_o(eirq)
    );

    // monitor: compares queued expectations half a cycle after the edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{st: status, c: cnt, run: running, bsy: busy, fi: firq, ei: eirq};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual st=%b cnt=%0d run=%b busy=%b firq=%b eirq=%b expected st=%b cnt=%0d run=%b busy=%b firq=%b eirq=%b",
                         t, a.st, a.c, a.run, a.bsy, a.fi, a.ei, e.st, e.c, e.run, e.bsy, e.fi, e.ei);
            end
        end
    end

    task automatic cyc(input logic t, input logic d, input logic w,
                       input logic [1:0] a, input logic [DATA_W-1:0] dat);
        @(negedge clk);
        trig = t; done = d; wr_en = w; wr_addr = a; wr_data = dat;
        @(posedge clk);
        #0.5;
        trig = 1'b0; done = 1'b0; wr_en = 1'b0;
    endtask

    task automatic expect_st(input string tag, input logic [2:0] st, input logic [CNT_W-1:0] c,
                             input logic r, input logic b, input logic fi, input logic ei);
        exp_q.push_back('{st: st, c: c, run: r, bsy: b, fi: fi, ei: ei});
        tag_q.push_back(tag);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [DATA_W-1:0] dat);
        cyc(1'b0, 1'b0, 1'b1, a, dat);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0);
        expect_st("R1 reset", 3'b000, 0, 0, 0, 0, 0);

        wreg(2'd3, 16'h3);
        wreg(2'd0, 16'h1);
        expect_st("R2 arm", 3'b000, 0, 1, 0, 0, 0);
        wreg(2'd1, 16'd0);

        cyc(1, 0, 0, 0, 0);
        expect_st("R3 trigger starts frame", 3'b000, 0, 1, 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
        expect_st("R12 trigger while busy ignored", 3'b000, 0, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 0);
        expect_st("R3 R4 frame done, limit zero", 3'b001, 0, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);
        expect_st("R10 clear frame bit", 3'b000, 0, 1, 0, 0, 0);

        // limit 2: last flag on the third frame
        wreg(2'd1, 16'd2);
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R5 frame 1", 3'b001, 1, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R5 frame 2", 3'b001, 2, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R5 frame 3 sets last", 3'b011, 0, 1, 0, 1, 0);

        wreg(2'd2, 16'h2);
        expect_st("R10 partial clear keeps bit 0", 3'b001, 0, 1, 0, 1, 0);
        wreg(2'd3, 16'h2);
        expect_st("R11 masked frame bit", 3'b001, 0, 1, 0, 0, 0);
        wreg(2'd3, 16'h3);
        wreg(2'd2, 16'h1);
        expect_st("R10 cleared", 3'b000, 0, 1, 0, 0, 0);

        // set wins over clear in the same cycle
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 1, 2'd2, 16'h1);
        expect_st("R10 set wins over clear", 3'b001, 1, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);

        // lowered limit below count
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R5 count to 2", 3'b001, 2, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);
        wreg(2'd1, 16'd1);
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R6 lowered limit no immediate flag", 3'b001, 3, 1, 0, 1, 0);
        wreg(2'd2, 16'h1);
        for (int i = 0; i < 254; i++) begin
            cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
            expect_st("R6 counting through wrap", 3'b001, CNT_W'((4 + i) % 256), 1, 0, 1, 0);
            wreg(2'd2, 16'h1);
        end
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R6 flag on exact match", 3'b011, 0, 1, 0, 1, 0);
        wreg(2'd2, 16'h3);

        // overrun
        wreg(2'd1, 16'd0);
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        expect_st("R4 frame done pending", 3'b001, 0, 1, 0, 1, 0);
        cyc(1, 0, 0, 0, 0);
        expect_st("R7 overrun", 3'b101, 0, 0, 0, 1, 1);
        cyc(1, 0, 0, 0, 0);
        expect_st("R8 halted trigger", 3'b101, 0, 0, 0, 1, 1);
        wreg(2'd0, 16'h1);
        expect_st("R9 arm ignored while error", 3'b101, 0, 0, 0, 1, 1);
        wreg(2'd2, 16'h4);
        expect_st("R9 error cleared", 3'b001, 0, 0, 0, 1, 0);
        wreg(2'd2, 16'h1);
        wreg(2'd0, 16'h1);
        expect_st("R9 rearmed", 3'b000, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        expect_st("R9 frame after rearm", 3'b000, 0, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 0);
        expect_st("R3 frame after rearm done", 3'b001, 0, 1, 0, 1, 0);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule